// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the stores of an out-of-order core in program order, from dispatch until their write reaches the cache. A store takes a slot at dispatch and is handed back a tag: the slot index plus a wrap bit. Its address and its data arrive later, each on its own port and in any order. The retire logic marks stores committed oldest-first. Committed stores leave from the head, one per accepted cache handshake, so the queue never reorders stores among themselves. A flush throws away every store that has not yet committed.

A load presents a word address and an age, which is the allocation tag that was current when the load was dispatched. Only the stores allocated before that tag take part in the search, and every slot has its own comparator. Of the older stores whose address equals the load address, the youngest one decides the result. If its data is present, that data is forwarded and the load does not need the cache. If its data is still missing, the load is told to wait. Apart from this, a separate flag reports that at least one older store still has no address, so the load can decide whether to speculate. Forwarding is whole-word only.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, `cache_req_valid` is 0, and a load finds no match.
- R2: Each accepted allocation returns the current `alloc_tag` ({wrap bit, slot index}) and advances it by one. `alloc_ready` falls when DEPTH stores are held. An allocation attempt made while the queue is full is ignored and the tag does not move.
- R3: A load forwards (`ld_fwd`=1, `ld_data` = store data) when an older store has a known address equal to the load address and its data present.
- R4: When several older stores match, the data of the youngest of them in program order is forwarded. This also holds when the matching stores straddle the wrap of the slot index.
- R5: Stores allocated at or after the load's age take no part in the search. A load whose age lies behind the head sees no older stores.
- R6: `ld_addr_unk` is 1 when any store older than the load still has no address. Forwarding from a known matching store is unaffected by this flag.
- R7: When the youngest older matching store has no data yet, `ld_data_wait` is 1 and `ld_fwd` is 0.
- R8: `cache_req_valid` is 1 only while the head store is committed. Requests carry the stores' addresses and data in program order, and the queue advances by one per cycle with `cache_req_ready` high. While the request is not accepted, the request stays valid and unchanged.
- R9: `flush` discards all uncommitted stores, so the next tag returned equals the commit position. Committed stores still drain afterwards. A commit in the flush cycle is ignored.
- R10: With no older store at the load address, `ld_fwd` and `ld_data_wait` are 0 and `ld_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all uncommitted stores |
| alloc_valid | input | 1 | Request a new store slot |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | PW+1 | Tag given to the store being allocated |
| addr_valid | input | 1 | Write an address into a slot |
| addr_idx | input | PW | Slot receiving the address |
| addr_value | input | AW | Store word address |
| data_valid | input | 1 | Write data into a slot |
| data_idx | input | PW | Slot receiving the data |
| data_value | input | DW | Store data word |
| commit_valid | input | 1 | Mark the oldest uncommitted store as committed |
| cache_req_valid | output | 1 | Head store ready to write the cache |
| cache_req_addr | output | AW | Address of the head store |
| cache_req_data | output | DW | Data of the head store |
| cache_req_ready | input | 1 | Cache accepts the write |
| ld_addr | input | AW | Load word address |
| ld_age | input | PW+1 | Allocation tag snapshot of the load |
| ld_fwd | output | 1 | Data forwarded from the queue |
| ld_data | output | DW | Forwarded data |
| ld_data_wait | output | 1 | Youngest older match has no data yet |
| ld_addr_unk | output | 1 | An older store has an unknown address |

## Verification
The assertions assume well-formed inputs from the core. A commit is raised only when the next uncommitted store has both its address and its data. Address and data fills target slots that are allocated. A load's age never runs ahead of the current allocation tag. The stimulus keeps to all of these rules: it commits only the stores it has filled, and it takes every load age from tags it has already been handed. Under these rules the checks cover the tag sequence, the stability of the cache request, the reset state and the mutual exclusion of forwarding and waiting.

// File: rtl/store_fwd_queue.sv
`timescale 1ns/1ps
module store_fwd_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        alloc_valid,
  output logic                        alloc_ready,
  output logic [$clog2(DEPTH):0]      alloc_tag,
  input  logic                        addr_valid,
  input  logic [$clog2(DEPTH)-1:0]    addr_idx,
  input  logic [AW-1:0]               addr_value,
  input  logic                        data_valid,
  input  logic [$clog2(DEPTH)-1:0]    data_idx,
  input  logic [DW-1:0]               data_value,
  input  logic                        commit_valid,
  output logic                        cache_req_valid,
  output logic [AW-1:0]               cache_req_addr,
  output logic [DW-1:0]               cache_req_data,
  input  logic                        cache_req_ready,
  input  logic [AW-1:0]               ld_addr,
  input  logic [$clog2(DEPTH):0]      ld_age,
  output logic                        ld_fwd,
  output logic [DW-1:0]               ld_data,
  output logic                        ld_data_wait,
  output logic                        ld_addr_unk
);
  localparam int PW = $clog2(DEPTH);

  logic [PW:0]    head_q, cmt_q, tail_q;
  logic [DEPTH-1:0] addr_ok, data_ok;
  logic [AW-1:0]  addr_mem [DEPTH];
  logic [DW-1:0]  data_mem [DEPTH];

  logic [PW:0] occ;
  logic        alloc_fire, drain_fire;
  logic [PW-1:0] head_idx;

  assign occ         = tail_q - head_q;
  assign alloc_ready = !occ[PW];
  assign alloc_tag   = tail_q;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush;
  assign head_idx    = head_q[PW-1:0];

  assign cache_req_valid = (cmt_q != head_q);
  assign cache_req_addr  = addr_mem[head_idx];
  assign cache_req_data  = data_mem[head_idx];
  assign drain_fire      = cache_req_valid && cache_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      cmt_q   <= '0;
      tail_q  <= '0;
      addr_ok <= '0;
      data_ok <= '0;
    end else begin
      if (drain_fire)
        head_q <= head_q + 1'b1;
      if (flush)
        tail_q <= cmt_q;
      else begin
        if (alloc_fire) begin
          tail_q <= tail_q + 1'b1;
          addr_ok[tail_q[PW-1:0]] <= 1'b0;
          data_ok[tail_q[PW-1:0]] <= 1'b0;
        end
        if (commit_valid && cmt_q != tail_q)
          cmt_q <= cmt_q + 1'b1;
      end
      if (addr_valid) begin
        addr_ok[addr_idx]  <= 1'b1;
        addr_mem[addr_idx] <= addr_value;
      end
      if (data_valid) begin
        data_ok[data_idx]  <= 1'b1;
        data_mem[data_idx] <= data_value;
      end
    end
  end

  logic [PW:0]   age_span, older_cnt;
  logic          hit;
  logic [PW-1:0] hit_idx;

  assign age_span  = ld_age - head_q;
  assign older_cnt = (age_span > occ) ? '0 : age_span;

  always_comb begin
    hit         = 1'b0;
    hit_idx     = '0;
    ld_addr_unk = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head_idx + k[PW-1:0];
      if ((PW+1)'(k) < older_cnt) begin
        if (!addr_ok[idx])
          ld_addr_unk = 1'b1;
        else if (addr_mem[idx] == ld_addr) begin
          hit     = 1'b1;
          hit_idx = idx;
        end
      end
    end
  end

  assign ld_fwd       = hit && data_ok[hit_idx];
  assign ld_data_wait = hit && !data_ok[hit_idx];
  assign ld_data      = ld_fwd ? data_mem[hit_idx] : '0;

endmodule

// File: rtl/store_fwd_queue_sva.sv
`timescale 1ns/1ps
module store_fwd_queue_sva #(
  parameter int PW = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [PW:0]   alloc_tag,
  input logic          cache_req_valid,
  input logic          cache_req_ready,
  input logic [AW-1:0] cache_req_addr,
  input logic [DW-1:0] cache_req_data,
  input logic          ld_fwd,
  input logic          ld_data_wait
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!cache_req_valid && alloc_ready));

  assert_tag_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !flush) |=> alloc_tag == (PW+1)'($past(alloc_tag) + 1'b1));

  assert_full_holds_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush && !($past(flush))) |=> $stable(alloc_tag));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req_valid && !cache_req_ready) |=>
      (cache_req_valid && $stable(cache_req_addr) && $stable(cache_req_data)));

  assert_fwd_or_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_fwd, ld_data_wait}));
endmodule

bind store_fwd_queue store_fwd_queue_sva #(.PW($clog2(DEPTH)), .AW(AW), .DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
  .cache_req_addr(cache_req_addr), .cache_req_data(cache_req_data),
  .ld_fwd(ld_fwd), .ld_data_wait(ld_data_wait)
);

// File: tb/store_fwd_queue_bench.sv
`timescale 1ns/1ps
module store_fwd_queue_bench;
  localparam int DEPTH = 8;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0, flush = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [PW:0] alloc_tag;
  logic addr_valid = 0, data_valid = 0, commit_valid = 0;
  logic [PW-1:0] addr_idx = 0, data_idx = 0;
  logic [31:0] addr_value = 0, data_value = 0;
  logic cache_req_valid, cache_req_ready = 0;
  logic [31:0] cache_req_addr, cache_req_data;
  logic [31:0] ld_addr = 0;
  logic [PW:0] ld_age = 0;
  logic ld_fwd, ld_data_wait, ld_addr_unk;
  logic [31:0] ld_data;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  store_fwd_queue #(.DEPTH(DEPTH), .AW(32), .DW(32)) u_store_fwd_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
    .data_valid(data_valid), .data_idx(data_idx), .data_value(data_value),
    .commit_valid(commit_valid),
    .cache_req_valid(cache_req_valid), .cache_req_addr(cache_req_addr),
    .cache_req_data(cache_req_data), .cache_req_ready(cache_req_ready),
    .ld_addr(ld_addr), .ld_age(ld_age), .ld_fwd(ld_fwd), .ld_data(ld_data),
    .ld_data_wait(ld_data_wait), .ld_addr_unk(ld_addr_unk)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] a;
    logic [3:0]  age;
    logic        fwd;
    logic        wt;
    logic        unk;
    logic [7:0]  d;
  } vec_t;

  // slots 0..5: 0x100/A0, 0x200/B1, 0x100/C2, 0x300/no data, no addr, 0x100/D5
  localparam vec_t TBL [10] = '{
    '{4'd3,  16'h0100, 4'd1, 1'b1, 1'b0, 1'b0, 8'hA0}, // R3
    '{4'd4,  16'h0100, 4'd3, 1'b1, 1'b0, 1'b0, 8'hC2}, // R4
    '{4'd3,  16'h0200, 4'd3, 1'b1, 1'b0, 1'b0, 8'hB1}, // R3
    '{4'd5,  16'h0100, 4'd2, 1'b1, 1'b0, 1'b0, 8'hA0}, // R5
    '{4'd7,  16'h0300, 4'd4, 1'b0, 1'b1, 1'b0, 8'h00}, // R7
    '{4'd10, 16'h0400, 4'd3, 1'b0, 1'b0, 1'b0, 8'h00}, // R10
    '{4'd6,  16'h0100, 4'd5, 1'b1, 1'b0, 1'b1, 8'hC2}, // R6
    '{4'd4,  16'h0100, 4'd6, 1'b1, 1'b0, 1'b1, 8'hD5}, // R4
    '{4'd5,  16'h0100, 4'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R5
    '{4'd5,  16'h0300, 4'd3, 1'b0, 1'b0, 1'b0, 8'h00}  // R5
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic alloc();
    alloc_valid = 1; tick(); alloc_valid = 0;
  endtask

  task automatic put_addr(input int idx, input logic [31:0] a);
    addr_valid = 1; addr_idx = idx[PW-1:0]; addr_value = a; tick(); addr_valid = 0;
  endtask

  task automatic put_data(input int idx, input logic [31:0] d);
    data_valid = 1; data_idx = idx[PW-1:0]; data_value = d; tick(); data_valid = 0;
  endtask

  task automatic load(input logic [31:0] a, input logic [PW:0] age);
    ld_addr = a; ld_age = age; #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check(1, {31'd0, alloc_ready}, 32'd1);
    check(1, {28'd0, alloc_tag}, 32'd0);
    check(1, {31'd0, cache_req_valid}, 32'd0);
    load(32'h100, 4'd0);
    check(1, {30'd0, ld_fwd, ld_data_wait}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      check(2, {28'd0, alloc_tag}, i); // R2 tag sequence
      alloc();
    end
    put_addr(0, 32'h100); put_data(0, 32'hA0);
    put_addr(1, 32'h200); put_data(1, 32'hB1);
    put_addr(2, 32'h100); put_data(2, 32'hC2);
    put_addr(3, 32'h300);
    put_addr(5, 32'h100); put_data(5, 32'hD5);

    foreach (TBL[i]) begin
      load({16'd0, TBL[i].a}, TBL[i].age);
      check(TBL[i].req, {ld_fwd, ld_data_wait, ld_addr_unk, 21'd0, ld_data[7:0]},
            {TBL[i].fwd, TBL[i].wt, TBL[i].unk, 21'd0, TBL[i].d});
    end

    // R2 fill to full, ignored allocation
    alloc(); alloc();
    check(2, {31'd0, alloc_ready}, 32'd0);
    check(2, {28'd0, alloc_tag}, 32'd8);
    alloc();
    check(2, {28'd0, alloc_tag}, 32'd8);

    // R8 commit three, cache not ready: request held
    commit_valid = 1; tick(); tick(); tick(); commit_valid = 0;
    check(8, {cache_req_valid, 23'd0, cache_req_data[7:0]}, {1'b1, 23'd0, 8'hA0});
    tick();
    check(8, {cache_req_valid, 15'd0, cache_req_addr[15:0]}, {1'b1, 15'd0, 16'h100});

    // R9 flush drops uncommitted stores, commit in same cycle ignored
    flush = 1; commit_valid = 1; tick(); flush = 0; commit_valid = 0;
    check(9, {28'd0, alloc_tag}, 32'd3);
    check(9, {31'd0, alloc_ready}, 32'd1);

    // R8 / R9 drain committed stores in order
    cache_req_ready = 1; #1;
    check(8, {cache_req_valid, 23'd0, cache_req_data[7:0]}, {1'b1, 23'd0, 8'hA0});
    tick();
    check(8, {cache_req_valid, 23'd0, cache_req_data[7:0]}, {1'b1, 23'd0, 8'hB1});
    tick();
    check(9, {cache_req_valid, 23'd0, cache_req_data[7:0]}, {1'b1, 23'd0, 8'hC2});
    tick();
    check(9, {31'd0, cache_req_valid}, 32'd0);
    cache_req_ready = 0;

    // R4 wrap: tags 3..8 occupy slots 3..7,0
    for (int i = 0; i < 6; i++) alloc();
    for (int i = 3; i < 7; i++) begin
      put_addr(i, 32'h600 + i); put_data(i, 32'h60 + i);
    end
    put_addr(7, 32'h500); put_data(7, 32'h77);
    load(32'h500, 4'd9);
    check(6, {31'd0, ld_addr_unk}, 32'd1); // R6 slot 0 address still unknown
    put_addr(0, 32'h500); put_data(0, 32'h88);
    load(32'h500, 4'd9);
    check(4, {ld_fwd, ld_addr_unk, 22'd0, ld_data[7:0]}, {1'b1, 1'b0, 22'd0, 8'h88});
    load(32'h500, 4'd8);
    check(4, {ld_fwd, 23'd0, ld_data[7:0]}, {1'b1, 23'd0, 8'h77});
    load(32'h500, 4'd2); // R5 age behind head
    check(5, {30'd0, ld_fwd, ld_data_wait}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule